// File: doc/BRIEF.md
# Dual-Address Buffered DMA Sequencer

This block sequences one DMA channel that moves data in dual-address fashion: every move is split into a read phase and a write phase, and the bytes pass through an internal staging buffer. The sequencer tracks only how many bytes that buffer holds. It never stores the data. It answers the peripheral's request/acknowledge/terminate handshake and issues read and write phases to a bus engine. It can also stop the channel early when the peripheral asks for termination.

In peripheral-to-memory mode, each request pulls one chunk from the peripheral into the buffer. When a full memory burst has built up, the buffer is drained to memory on its own. In memory-to-peripheral mode, the buffer is refilled with one memory burst whenever it can no longer supply a whole chunk, and each request hands one chunk to the peripheral. A memory-to-memory mode copies one burst per request. Termination is accepted at any time, but a phase pair that the sequencer has already committed to always runs to the end. At most one queued request is honoured after termination.

Phases go out on a valid/ready request port. `req_valid` rises with the phase kind and byte count and holds them steady until `req_ready` is seen high at a clock edge. That edge is the moment the phase is done, so the bus engine applies back-pressure just by holding `req_ready` low for as long as the phase lasts. The configuration inputs must stay stable while the channel is armed.

Top module: `dseq_top`

## Requirements
- R1: After reset the channel is disarmed: `armed`, `req_valid`, `dack` and `stop_pulse` are all low.
- R2: With `cfg_mode`=0 (peripheral to memory), each serviced request issues one phase with `req_periph`=1, `req_write`=0 and `req_bytes`=`cfg_chunk`. `req_periph`=1 marks the peripheral side and `req_write`=1 marks a write.
- R3: In mode 0, when a peripheral read brings the buffered count to `cfg_burst`, a memory write (`req_periph`=0, `req_write`=1) of `cfg_burst` bytes follows with no request, and the count returns to zero.
- R4: In mode 0, an accepted termination lets a memory write already in flight finish. It then services a request that was queued before it, writes any remaining buffered bytes to memory in one phase, and stops.
- R5: With `cfg_mode`=1 (memory to peripheral), a request that finds fewer than `cfg_chunk` bytes buffered triggers a memory read of `cfg_burst` bytes, followed at once by a peripheral write of `cfg_chunk` bytes. Otherwise the request triggers the peripheral write alone.
- R6: In mode 1, termination never splits a refill read from the write that follows it. With no queued request the channel stops at once. With one queued request, that request is serviced first and then the channel stops.
- R7: `dack` is high during every peripheral-side phase and never during a memory-side phase.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_periph` and `req_bytes` hold their values.
- R9: `cfg_err` is high when the chunk or burst is zero, when the burst is not a whole multiple of the chunk, when `cfg_mode`=3, when the memory-side terminate enable is set (`cfg_done_dst` in mode 0, `cfg_done_src` in mode 1), or when either enable is set in mode 2. `arm` has no effect while `cfg_err` is high.
- R10: `done_in` is ignored unless the peripheral-side enable is set (`cfg_done_src` in mode 0, `cfg_done_dst` in mode 1).
- R11: With `cfg_mode`=2 (memory to memory), each request yields a memory read of `cfg_burst` bytes followed by a memory write of `cfg_burst` bytes, and `done_in` has no effect.
- R12: When the channel stops, `stop_pulse` is high for exactly one cycle, `armed` falls, and requests are then ignored until `arm`.
- R13: Requests arriving while one is already queued merge into it: the queue is one deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 peripheral to memory, 1 memory to peripheral, 2 memory to memory, 3 invalid |
| cfg_chunk | input | CW | Peripheral chunk size in bytes |
| cfg_burst | input | CW | Memory burst size in bytes |
| cfg_done_src | input | 1 | Terminate enable for the source side |
| cfg_done_dst | input | 1 | Terminate enable for the destination side |
| arm | input | 1 | Pulse to arm a disarmed channel |
| dreq | input | 1 | Peripheral transfer request, one per high cycle |
| done_in | input | 1 | Peripheral termination request |
| dack | output | 1 | Peripheral acknowledge, high during peripheral phases |
| req_valid | output | 1 | Phase request valid |
| req_ready | input | 1 | Phase complete / accepted |
| req_write | output | 1 | 1 = write phase, 0 = read phase |
| req_periph | output | 1 | 1 = peripheral side, 0 = memory side |
| req_bytes | output | CW | Byte count of the phase |
| armed | output | 1 | Channel armed |
| stop_pulse | output | 1 | One-cycle pulse when the channel stops |
| cfg_err | output | 1 | Configuration invalid |

## Verification
The hardest case to reach is termination arriving while a committed phase is still in flight and a second request is already queued. In that case, the order in which the remaining phases drain depends on both the buffer level and the queue. The bench produces it by issuing request pulses on consecutive cycles while the bus responder stalls each phase. It waits for the memory phase to appear on the request port and asserts `done_in` only then. Expected phase counts and byte totals for every chunk/burst/request-count combination are computed arithmetically.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [1:0] {
    XM_P2M = 2'd0,
    XM_M2P = 2'd1,
    XM_M2M = 2'd2,
    XM_RSV = 2'd3
  } xmode_e;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_WAIT,
    PH_PRD,
    PH_PWR,
    PH_MRD,
    PH_MWR
  } phase_e;

  typedef enum logic [1:0] {
    FC_HOLD,
    FC_CLR,
    FC_ADD,
    FC_SUB
  } fill_op_e;
endpackage

// File: rtl/dseq_cfg_chk.sv
module dseq_cfg_chk
  import dseq_pkg::*;
#(
  parameter int CW = 8
) (
  input  xmode_e          mode,
  input  logic [CW-1:0]   chunk,
  input  logic [CW-1:0]   burst,
  input  logic            en_src,
  input  logic            en_dst,
  output logic            cfg_err,
  output logic            done_honor
);
  logic [CW-1:0] rem;
  logic          size_bad;
  logic          en_bad;

  always_comb begin
    rem = '0;
    if (chunk != '0) rem = burst % chunk;
    size_bad = (chunk == '0) || (burst == '0) || (rem != '0);
    case (mode)
      XM_P2M:  en_bad = en_dst;
      XM_M2P:  en_bad = en_src;
      XM_M2M:  en_bad = en_src | en_dst;
      default: en_bad = 1'b1;
    endcase
    cfg_err    = size_bad | en_bad;
    done_honor = ((mode == XM_P2M) && en_src) || ((mode == XM_M2P) && en_dst);
  end
endmodule

// File: rtl/dseq_req_latch.sv
module dseq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic dreq,
  input  logic done_in,
  input  logic honor,
  input  logic take,
  output logic pend,
  output logic done_lat
);
  // One-deep request queue; requests after termination are not queued.
  always_ff @(posedge clk) begin
    if (!rst_n || !armed) begin
      pend     <= 1'b0;
      done_lat <= 1'b0;
    end else begin
      pend     <= (pend & ~take) | (dreq & ~done_lat);
      done_lat <= done_lat | (done_in & honor);
    end
  end
endmodule

// File: rtl/dseq_fill_ctr.sv
module dseq_fill_ctr
  import dseq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fill_op_e      op,
  input  logic [CW-1:0] amt,
  output logic [CW-1:0] fill
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else begin
      case (op)
        FC_CLR:  fill <= '0;
        FC_ADD:  fill <= fill + amt;
        FC_SUB:  fill <= fill - amt;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_chunk,
  input  logic [CW-1:0] cfg_burst,
  input  logic          cfg_done_src,
  input  logic          cfg_done_dst,
  input  logic          arm,
  input  logic          dreq,
  input  logic          done_in,
  output logic          dack,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic          req_periph,
  output logic [CW-1:0] req_bytes,
  output logic          armed,
  output logic          stop_pulse,
  output logic          cfg_err
);
  localparam int SW = CW + 1;

  xmode_e        mode;
  phase_e        ph, ph_n, svc_ph;
  logic          stop_n;
  logic          honor, pend, done_lat, take, fin;
  fill_op_e      fop;
  logic [CW-1:0] famt, fill;
  logic [SW-1:0] fill_after_rd;

  assign mode = xmode_e'(cfg_mode);

  dseq_cfg_chk #(.CW(CW)) u_cfg (
    .mode(mode), .chunk(cfg_chunk), .burst(cfg_burst),
    .en_src(cfg_done_src), .en_dst(cfg_done_dst),
    .cfg_err(cfg_err), .done_honor(honor)
  );

  dseq_req_latch u_lat (
    .clk(clk), .rst_n(rst_n), .armed(armed), .dreq(dreq),
    .done_in(done_in), .honor(honor), .take(take),
    .pend(pend), .done_lat(done_lat)
  );

  dseq_fill_ctr #(.CW(CW)) u_fill (
    .clk(clk), .rst_n(rst_n), .op(fop), .amt(famt), .fill(fill)
  );

  assign armed         = (ph != PH_OFF);
  assign fin           = req_valid & req_ready;
  assign fill_after_rd = {1'b0, fill} + {1'b0, cfg_chunk};

  // Phase chosen when a queued request is taken
  always_comb begin
    case (mode)
      XM_P2M:  svc_ph = PH_PRD;
      XM_M2P:  svc_ph = (fill >= cfg_chunk) ? PH_PWR : PH_MRD;
      default: svc_ph = PH_MRD;
    endcase
  end

  always_comb begin
    ph_n   = ph;
    stop_n = 1'b0;
    take   = 1'b0;
    case (ph)
      PH_OFF: if (arm && !cfg_err) ph_n = PH_WAIT;
      PH_WAIT: begin
        if (pend) begin
          ph_n = svc_ph;
          take = 1'b1;
        end else if (done_lat) begin
          if (mode == XM_P2M && fill != '0) begin
            ph_n = PH_MWR;
          end else begin
            ph_n   = PH_OFF;
            stop_n = 1'b1;
          end
        end
      end
      PH_PRD: if (fin) ph_n = (fill_after_rd >= {1'b0, cfg_burst}) ? PH_MWR : PH_WAIT;
      PH_PWR: if (fin) ph_n = PH_WAIT;
      PH_MRD: if (fin) ph_n = (mode == XM_M2M) ? PH_MWR : PH_PWR;
      PH_MWR: if (fin) ph_n = PH_WAIT;
      default: ph_n = PH_OFF;
    endcase
  end

  always_comb begin
    fop  = FC_HOLD;
    famt = cfg_chunk;
    case (ph)
      PH_OFF: fop = FC_CLR;
      PH_PRD: if (fin) fop = FC_ADD;
      PH_PWR: if (fin) fop = FC_SUB;
      PH_MRD: if (fin) begin fop = FC_ADD; famt = cfg_burst; end
      PH_MWR: if (fin) fop = FC_CLR;
      default: fop = FC_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_OFF;
      stop_pulse <= 1'b0;
    end else begin
      ph         <= ph_n;
      stop_pulse <= stop_n;
    end
  end

  always_comb begin
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_periph = 1'b0;
    req_bytes  = '0;
    case (ph)
      PH_PRD: begin req_valid = 1'b1; req_periph = 1'b1; req_bytes = cfg_chunk; end
      PH_PWR: begin req_valid = 1'b1; req_periph = 1'b1; req_write = 1'b1; req_bytes = cfg_chunk; end
      PH_MRD: begin req_valid = 1'b1; req_bytes = cfg_burst; end
      PH_MWR: begin req_valid = 1'b1; req_write = 1'b1; req_bytes = fill; end
      default: ;
    endcase
  end

  assign dack = (ph == PH_PRD) || (ph == PH_PWR);
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic [CW-1:0] cfg_burst,
  input logic          dack,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          req_periph,
  input logic [CW-1:0] req_bytes,
  input logic          armed,
  input logic          stop_pulse
);
  // R1
  idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !req_valid);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_bytes) &&
                                   $stable(req_write) && $stable(req_periph)));
  // R3
  mwr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_periph && req_write) |-> (req_bytes != '0 && req_bytes <= cfg_burst));
  // R2
  p2m_periph_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 && dack) |-> !req_write);
  // R6
  refill_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && req_valid && req_ready && !req_periph && !req_write)
      |=> (req_valid && req_periph && req_write));
  // R11
  m2m_nodack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) |-> !dack);
  // R12
  stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);
  // R12
  stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !armed);
endmodule

bind dseq_top dseq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_burst(cfg_burst),
  .dack(dack), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_periph(req_periph), .req_bytes(req_bytes),
  .armed(armed), .stop_pulse(stop_pulse)
);

// File: tb/dseq_top_tb.sv
module dseq_top_tb;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [CW-1:0] cfg_chunk = 8'd1, cfg_burst = 8'd1;
  logic cfg_done_src = 1'b0, cfg_done_dst = 1'b0;
  logic arm = 1'b0, dreq = 1'b0, done_in = 1'b0, req_ready = 1'b0;
  logic dack, req_valid, req_write, req_periph, armed, stop_pulse, cfg_err;
  logic [CW-1:0] req_bytes;

  int n_chk = 0, n_fail = 0;
  int n_prd, n_pwr, n_mrd, n_mwr, b_prd, b_pwr, b_mrd, b_mwr, n_stop;
  int dack_bad = 0, hold_bad = 0, wcnt = 0;
  logic p_valid = 0, p_ready = 0, p_write = 0, p_periph = 0;
  logic [CW-1:0] p_bytes = '0;

  always #2 clk = ~clk;

  dseq_top #(.CW(CW)) u_dut (.*);

  // Bus responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0; wcnt = 0; p_valid = 0; p_ready = 0;
    end else begin
      if (stop_pulse) n_stop++;
      if (dack != (req_valid && req_periph)) dack_bad++;
      if (p_valid && !p_ready &&
          (!req_valid || req_bytes != p_bytes || req_write != p_write || req_periph != p_periph))
        hold_bad++;
      if (req_valid && !req_ready) begin
        if (wcnt >= 1) begin
          req_ready = 1'b1; wcnt = 0;
          if (req_periph && !req_write) begin n_prd++; b_prd += int'(req_bytes); end
          if (req_periph && req_write)  begin n_pwr++; b_pwr += int'(req_bytes); end
          if (!req_periph && !req_write) begin n_mrd++; b_mrd += int'(req_bytes); end
          if (!req_periph && req_write) begin n_mwr++; b_mwr += int'(req_bytes); end
        end else wcnt++;
      end else begin
        req_ready = 1'b0; wcnt = 0;
      end
      p_valid = req_valid; p_ready = req_ready; p_bytes = req_bytes;
      p_write = req_write; p_periph = req_periph;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    n_prd = 0; n_pwr = 0; n_mrd = 0; n_mwr = 0;
    b_prd = 0; b_pwr = 0; b_mrd = 0; b_mwr = 0; n_stop = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setcfg(int m, int c, int b, bit es, bit ed);
    @(negedge clk);
    cfg_mode = 2'(m); cfg_chunk = CW'(c); cfg_burst = CW'(b);
    cfg_done_src = es; cfg_done_dst = ed;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_dreq();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_in = 1'b1;
    @(negedge clk); done_in = 1'b0;
  endtask

  task automatic settle();
    int idle = 0;
    int g = 0;
    while (idle < 6 && g < 500) begin
      @(negedge clk); g++;
      if (req_valid) idle = 0; else idle++;
    end
  endtask

  task automatic wait_mem_phase(bit wr);
    int g = 0;
    while (!(req_valid && !req_periph && req_write == wr) && g < 200) begin
      @(negedge clk); g++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_log();
    do_reset();
    @(negedge clk);
    // R1
    chk("R1 armed", int'(armed), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 dack", int'(dack), 0);
    chk("R1 stop_pulse", int'(stop_pulse), 0);

    // R2 R3 R4 R12: peripheral-to-memory sweep
    for (int c = 1; c <= 3; c++) begin
      for (int k = 1; k <= 3; k++) begin
        for (int n = 1; n <= 2 * k + 1; n++) begin
          setcfg(0, c, k * c, 1'b1, 1'b0);
          do_arm(); clr_log();
          for (int i = 0; i < n; i++) begin pulse_dreq(); settle(); end
          chk("R2 reads", n_prd, n);
          chk("R2 read bytes", b_prd, n * c);
          chk("R3 auto writes", n_mwr, n / k);
          chk("R3 auto bytes", b_mwr, (n / k) * k * c);
          pulse_done(); settle();
          chk("R4 writes after done", n_mwr, (n + k - 1) / k);
          chk("R4 bytes after done", b_mwr, n * c);
          chk("R12 stop count", n_stop, 1);
          chk("R12 disarmed", int'(armed), 0);
        end
      end
    end

    // R12: request ignored after stop
    clr_log(); pulse_dreq(); settle();
    chk("R12 ignored reads", n_prd + n_mwr, 0);
    chk("R12 still off", int'(armed), 0);

    // R5 R6: memory-to-peripheral sweep
    for (int c = 1; c <= 3; c++) begin
      for (int k = 1; k <= 3; k++) begin
        for (int n = 1; n <= 2 * k + 1; n++) begin
          setcfg(1, c, k * c, 1'b0, 1'b1);
          do_arm(); clr_log();
          for (int i = 0; i < n; i++) begin pulse_dreq(); settle(); end
          chk("R5 periph writes", n_pwr, n);
          chk("R5 write bytes", b_pwr, n * c);
          chk("R5 refills", n_mrd, (n + k - 1) / k);
          chk("R5 refill bytes", b_mrd, ((n + k - 1) / k) * k * c);
          pulse_done(); settle();
          chk("R6 no extra writes", n_pwr, n);
          chk("R6 no extra reads", n_mrd, (n + k - 1) / k);
          chk("R6 stop count", n_stop, 1);
        end
      end
    end

    // R6: done during refill read does not cancel the paired write
    setcfg(1, 2, 4, 1'b0, 1'b1); do_arm(); clr_log();
    pulse_dreq(); wait_mem_phase(1'b0);
    done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    settle();
    chk("R6 pair write", n_pwr, 1);
    chk("R6 pair read", n_mrd, 1);
    chk("R6 pair stop", n_stop, 1);

    // R6: done with one queued request
    setcfg(1, 2, 4, 1'b0, 1'b1); do_arm(); clr_log();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0; done_in = 1'b1;
    @(negedge clk); done_in = 1'b0;
    settle();
    chk("R6 pending writes", n_pwr, 2);
    chk("R6 pending reads", n_mrd, 1);
    chk("R6 pending stop", n_stop, 1);

    // R4: done with one queued request and a part-filled buffer
    setcfg(0, 1, 4, 1'b1, 1'b0); do_arm(); clr_log();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0; done_in = 1'b1;
    @(negedge clk); done_in = 1'b0;
    settle();
    chk("R4 pending reads", n_prd, 2);
    chk("R4 flush count", n_mwr, 1);
    chk("R4 flush bytes", b_mwr, 2);
    chk("R4 pending stop", n_stop, 1);

    // R4: done while the full-buffer write is in flight
    setcfg(0, 1, 2, 1'b1, 1'b0); do_arm(); clr_log();
    pulse_dreq(); settle();
    pulse_dreq(); wait_mem_phase(1'b1);
    done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    settle();
    chk("R4 inflight writes", n_mwr, 1);
    chk("R4 inflight bytes", b_mwr, 2);
    chk("R4 inflight stop", n_stop, 1);

    // R13: requests merge while one is queued
    setcfg(0, 1, 8, 1'b1, 1'b0); do_arm(); clr_log();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); dreq = 1'b0;
    settle();
    chk("R13 merged reads", n_prd, 2);
    pulse_done(); settle();
    chk("R13 stopped", int'(armed), 0);

    // R10: termination ignored when its enable is clear
    setcfg(0, 2, 4, 1'b0, 1'b0); do_arm(); clr_log();
    pulse_dreq(); settle();
    pulse_done(); settle();
    chk("R10 still armed", int'(armed), 1);
    chk("R10 no stop", n_stop, 0);
    chk("R10 no flush", n_mwr, 0);
    pulse_dreq(); settle();
    chk("R10 auto write bytes", b_mwr, 4);
    do_reset();

    // R11: memory-to-memory
    setcfg(2, 1, 4, 1'b0, 1'b0); do_arm(); clr_log();
    for (int i = 0; i < 3; i++) begin pulse_dreq(); settle(); end
    chk("R11 reads", n_mrd, 3);
    chk("R11 writes", n_mwr, 3);
    chk("R11 write bytes", b_mwr, 12);
    pulse_done(); settle();
    chk("R11 done ignored", int'(armed), 1);
    pulse_dreq(); settle();
    chk("R11 still serving", n_mrd, 4);
    do_reset();

    // R9: configuration errors
    setcfg(0, 2, 3, 1'b1, 1'b0); @(negedge clk);
    chk("R9 non-multiple", int'(cfg_err), 1);
    do_arm(); @(negedge clk);
    chk("R9 arm ignored", int'(armed), 0);
    setcfg(0, 2, 4, 1'b0, 1'b1); @(negedge clk);
    chk("R9 p2m mem enable", int'(cfg_err), 1);
    setcfg(1, 2, 4, 1'b1, 1'b0); @(negedge clk);
    chk("R9 m2p mem enable", int'(cfg_err), 1);
    setcfg(2, 1, 4, 1'b1, 1'b0); @(negedge clk);
    chk("R9 m2m enable", int'(cfg_err), 1);
    setcfg(0, 0, 4, 1'b0, 1'b0); @(negedge clk);
    chk("R9 zero chunk", int'(cfg_err), 1);
    setcfg(3, 1, 4, 1'b0, 1'b0); @(negedge clk);
    chk("R9 bad mode", int'(cfg_err), 1);
    setcfg(1, 2, 4, 1'b0, 1'b1); @(negedge clk);
    chk("R9 valid config", int'(cfg_err), 0);

    // R7 R8: collected over the whole run
    chk("R7 dack mismatches", dack_bad, 0);
    chk("R8 hold violations", hold_bad, 0);

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule